// File: doc/BRIEF.md
# Address Translation Buffer with Hardware Table Walk

This block maps 32-bit virtual addresses onto 32-bit physical addresses in 8 KB pages. An eight-entry, fully associative buffer holds recent translations, and a lookup compares every entry at once. When the page is already in the buffer, the block answers on the next cycle. The 13-bit page offset passes through unchanged, and the stored frame number takes the place of the page number.

When no entry matches, the block goes to memory for the translation. It computes the address of the table entry as a base address plus four times the page number, then issues a single read on a request/response port and waits for the answer, however long it takes. A resident entry is written into the buffer, and the pending lookup completes with the new frame number. A non-resident entry produces a fault response and leaves the buffer untouched.

Free slots are filled first. Once all slots hold translations, the least recently used one is overwritten. A flush input invalidates every translation in a single cycle.

Top module: `addr_xlate`

## Requirements
- R1: The response address is the 19-bit frame number placed above the unchanged low 13 bits of the request address.
- R2: A lookup that matches a valid entry raises rsp_valid with rsp_fault low on the cycle after it is accepted, and it issues no memory read.
- R3: A lookup that matches no entry issues exactly one read, at address pt_base + 4 × (request address bits 31:13), modulo 2^32.
- R4: The table entry is read as follows: bit 31 set means resident, and bits 18:0 hold the frame number. For a resident entry, the block installs the translation and answers with rsp_fault low and the address from R1.
- R5: For a non-resident entry, the block answers with rsp_fault high and installs nothing. A repeat lookup of the same page walks again, and no existing translation is displaced.
- R6: Empty slots are filled before any eviction. With all slots valid, a new translation replaces the least recently used entry.
- R7: A hit makes the matching entry the most recently used, in the same cycle.
- R8: While flush is high, req_ready is low. After a flush, every earlier translation misses.
- R9: While a walk is in progress, req_ready is low. mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen, and the walk waits for mem_rsp_valid with no time limit.
- R10: After reset, req_ready is high, rsp_valid and mem_req_valid are low, and the buffer holds no translations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all translations |
| pt_base | input | 32 | Physical base address of the page table |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Page not resident |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Table entry address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry contents |

## Verification
The stimulus first fills all eight slots and then forms a reuse pattern. That pattern hits some pages again, which reorders recency, and misses on others. Each miss therefore evicts a slot that differs between a correct least-recently-used order and a plain fill order or a random choice; whether a later lookup walks shows which slot was evicted. A non-resident page is looked up twice, followed by the page that would have been the victim. This shows that a fault neither installs an entry nor evicts one. Walk latencies of zero, one and several cycles, a flush, and a page number at the top of the address range cover the waiting logic and the table-address arithmetic.

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  parameter int PTE_W   = 32,
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PA_W-1:0] pt_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  typedef enum logic [1:0] {S_IDLE, S_ASK, S_WAIT} st_t;
  st_t st;

  logic [ENTRIES-1:0] vld, match;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PPN_W-1:0]   ppn [ENTRIES];
  logic [IDX_W-1:0]   age [ENTRIES];
  logic [VPN_W-1:0]   pend_vpn;
  logic [OFF_W-1:0]   pend_off;
  logic [IDX_W-1:0]   hit_idx, victim, touch_idx;
  logic               hit, accept, in_wait, resident, install, touch_en;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFF_W];

  assign req_ready     = (st == S_IDLE) && !flush;
  assign accept        = req_valid && req_ready;
  assign in_wait       = (st == S_WAIT);
  assign resident      = mem_rsp_data[PTE_W-1];
  assign install       = in_wait && mem_rsp_valid && resident && !flush;
  assign mem_req_valid = (st == S_ASK);
  assign mem_req_addr  = pt_base + (PA_W'(pend_vpn) << 2);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag[g] == req_vpn);
  end
  assign hit = |match;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) victim = IDX_W'(i);
  end

  assign touch_en  = (accept && hit) || install;
  assign touch_idx = install ? victim : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        age[i] <= IDX_W'(i);
        tag[i] <= '0;
        ppn[i] <= '0;
      end
    end else begin
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touch_idx) age[i] <= '0;
          else if (age[i] < age[touch_idx]) age[i] <= IDX_W'(age[i] + 1'b1);
        end
      if (flush) vld <= '0;
      else if (install) begin
        vld[victim] <= 1'b1;
        tag[victim] <= pend_vpn;
        ppn[victim] <= mem_rsp_data[PPN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      pend_vpn  <= '0;
      pend_off  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (accept) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_paddr <= {ppn[hit_idx], req_vaddr[OFF_W-1:0]};
            end else begin
              pend_vpn <= req_vpn;
              pend_off <= req_vaddr[OFF_W-1:0];
              st       <= S_ASK;
            end
          end
        S_ASK:
          if (mem_req_ready) st <= S_WAIT;
        S_WAIT:
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            st        <= S_IDLE;
            if (resident) begin
              rsp_fault <= 1'b0;
              rsp_paddr <= {mem_rsp_data[PPN_W-1:0], pend_off};
            end else begin
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk #(
  parameter int PA_W    = 32,
  parameter int PTE_W   = 32,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               accept,
  input logic               hit,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [PA_W-1:0]    mem_req_addr,
  input logic               mem_rsp_valid,
  input logic [PTE_W-1:0]   mem_rsp_data,
  input logic               in_wait,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] match
);
  assert_hit_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_valid && !rsp_fault);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || in_wait) |-> !req_ready);

  assert_no_install_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && mem_rsp_valid && !mem_rsp_data[PTE_W-1] && !flush |=> vld == $past(vld));

  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld == '0);

  assert_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

bind addr_xlate addr_xlate_chk #(.PA_W(PA_W), .PTE_W(PTE_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .accept(accept), .hit(hit),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_data(mem_rsp_data), .in_wait(in_wait), .vld(vld), .match(match)
);

// File: tb/test_addr_xlate.sv
module test_addr_xlate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [31:0] pt_base = BASE;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic rsp_valid, rsp_fault, mem_req_valid;
  logic [31:0] rsp_paddr, mem_req_addr;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, errors = 0;
  bit timeout = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_xlate i_addr_xlate (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // {expect_walk, expect_fault, vaddr}
  localparam logic [33:0] VEC [23] = '{
    {2'b10, 32'h0002_0004}, {2'b10, 32'h0002_2ABC}, {2'b10, 32'h0002_4010},
    {2'b10, 32'h0002_6FFF}, {2'b10, 32'h0002_9FFF}, {2'b10, 32'h0002_A000},
    {2'b10, 32'h0002_C123}, {2'b10, 32'h0002_E456}, {2'b00, 32'h0002_1FFC},
    {2'b10, 32'h0004_0008}, {2'b00, 32'h0002_0000}, {2'b00, 32'h0002_5555},
    {2'b10, 32'h0002_2000}, {2'b10, 32'h0002_6001}, {2'b00, 32'h0002_B000},
    {2'b10, 32'h0002_8800}, {2'b00, 32'h0002_E000}, {2'b10, 32'h0002_C000},
    {2'b10, 32'h0004_1234}, {2'b00, 32'h0002_4444}, {2'b11, 32'h0003_E100},
    {2'b11, 32'h0003_F000}, {2'b00, 32'h0002_3FFF}
  };

  function automatic logic [18:0] frame_of(input logic [18:0] vpn);
    return 19'(vpn * 3 + 19'h01234);
  endfunction

  function automatic logic [31:0] pte_of(input logic [31:0] addr);
    logic [18:0] vpn = 19'((addr - BASE) >> 2);
    return {vpn[4:0] != 5'h1F, 12'h000, frame_of(vpn)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input int lat, output bit walked,
                        output logic [31:0] pa, output bit flt,
                        output logic [31:0] wa, output int cyc);
    walked = 0; wa = '0; cyc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; cyc = 1;
    while (!rsp_valid) begin
      if (mem_req_valid) begin
        walked = 1; wa = mem_req_addr;
        check("R9 busy during walk", 32'(req_ready), 32'd0);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = pte_of(wa);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else @(negedge clk);
      cyc++;
    end
    pa = rsp_paddr; flt = rsp_fault;
  endtask

  task automatic probe(input logic [31:0] va, input int lat, input bit exp_walk,
                       input bit exp_fault, input string tag);
    bit w, f; logic [31:0] pa, wa; int cyc;
    lookup(va, lat, w, pa, f, wa, cyc);
    check({tag, " R6 R7 walk"}, 32'(w), 32'(exp_walk));
    check({tag, " R5 fault"}, 32'(f), 32'(exp_fault));
    if (w) check({tag, " R3 table address"}, wa, BASE + {11'b0, va[31:13], 2'b00});
    else   check({tag, " R2 hit latency"}, 32'(cyc), 32'd1);
    if (!exp_fault) check({tag, " R1 R4 paddr"}, pa, {frame_of(va[31:13]), va[12:0]});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 req_ready", 32'(req_ready), 32'd1);
        check("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R10 mem_req_valid", 32'(mem_req_valid), 32'd0);

        for (int i = 0; i < 23; i++)
          probe(VEC[i][31:0], i % 4, VEC[i][33], VEC[i][32], $sformatf("vec%0d", i));

        // R8 flush blocks acceptance and clears every translation
        @(negedge clk);
        flush = 1'b1;
        #1 check("R8 ready during flush", 32'(req_ready), 32'd0);
        @(negedge clk);
        flush = 1'b0;
        probe(32'h0002_4444, 2, 1'b1, 1'b0, "flush R8 page12");
        probe(32'h0004_0000, 0, 1'b1, 1'b0, "flush R8 page20");
        probe(32'h0002_4001, 0, 1'b0, 1'b0, "refill R4 page12");

        // R3 R5 highest page number, non-resident
        probe(32'hFFFF_E123, 7, 1'b1, 1'b1, "top R3 R5");
        // R9 long memory latency
        probe(32'h0006_0ABC, 40, 1'b1, 1'b0, "slow R9");
        probe(32'h0006_1ABD, 0, 1'b0, 1'b0, "slow R9 rehit");
      end
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule